// File: doc/BRIEF.md
# Tag Check Security Exception Unit

This unit guards a processor pipeline that carries a one-bit taint tag beside every register and memory word. Each cycle it may be handed one instruction: its class, the tags of the operands in each of four roles (source address, source data, destination data, destination address), and the tag of the value about to be loaded into the program counter. Software writes a check configuration word that gives every instruction class its own role mask. A set bit in that mask forbids tagged data in that role. A separate enable bit forbids execution from a tagged program counter.

When the instruction breaks a rule, the unit emits a single-cycle security exception pulse one clock later, with a cause code. The cause code names the offending class, or reports a tagged program counter. Taint may move freely through any role whose check bit is clear. This lets tainted arithmetic, for example, go unreported. Handling the exception and flushing the pipeline are left to the surrounding core.

Top module: `tag_check_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), and on the first sampled cycle after it, `exc_pulse` is 0 and `exc_cause` is 0.
- R2: For a valid instruction of class c (0 arithmetic, 1 branch, 2 jump, 3 shift, 4 logical, 5 comparison, 6 load/store), if any bit of `chk_cfg[4c+3:4c]` is set together with the matching bit of `role_tags`, then on the next clock `exc_pulse` is 1 and `exc_cause` is c.
- R3: A tagged role whose mask bit is clear for the current class never raises an exception. For example, an arithmetic instruction with all operand tags set and a zero arithmetic mask produces no pulse.
- R4: If `chk_cfg[28]` (execute check) is 1 and `next_pc_tag` is 1 on a valid cycle, then the next clock gives `exc_pulse` 1 with `exc_cause` 7. This cause wins over any class violation in the same cycle.
- R5: With `chk_cfg[28]` at 0, `next_pc_tag` has no effect on the outputs.
- R6: A check configuration of all zeros disables every check, whatever tags are presented.
- R7: A cycle with `chk_valid` low produces no exception on the next clock.
- R8: Class code 7 means "no checked class". Its role tags are never checked, but the execute check still applies.
- R9: The pulse lasts one clock per offending instruction. `exc_cause` is 0 in every cycle where `exc_pulse` is 0.
- R10: The load/store mask checks each role on its own. Bit 0 is the source address, bit 1 the source data, bit 2 the destination data and bit 3 the destination address. A tag in an unmasked role is ignored even when another role of the same class is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | An instruction is presented this cycle |
| ins_class | input | 3 | Instruction class code (0..6 checked, 7 none) |
| role_tags | input | 4 | Operand tags: src addr, src data, dst data, dst addr (bits 0..3) |
| next_pc_tag | input | 1 | Tag of the value about to become the program counter |
| chk_cfg | input | 29 | Per-class role masks (4 bits each) and execute-check enable at bit 28 |
| exc_pulse | output | 1 | Security exception, one clock wide |
| exc_cause | output | 3 | Offending class, or 7 for a tagged program counter |

## Verification
The bench walks every checked class with its mask set and its tags set, to catch a wrong field offset or a swapped class decode. A unit with that fault would report the wrong cause or stay silent. Load/store cases set one role mask bit and tag a neighbouring role, to expose a design that ORs whole masks or tags. Such a design would fire falsely. Collisions between a tagged program counter and a class violation check that cause 7 takes priority. Cases with the execute check disabled, an all-zero configuration, invalid cycles and class 7 must all stay quiet. A design that ignores an enable or the valid signal would pulse in those cases.

// File: rtl/tag_check_unit.sv
module tag_check_unit #(
  parameter int ROLES   = 4,
  parameter int CLASSES = 7,
  localparam int CAUSE_W  = $clog2(CLASSES + 1),
  localparam int CFG_W    = CLASSES * ROLES + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_valid,
  input  logic [CAUSE_W-1:0] ins_class,
  input  logic [ROLES-1:0]   role_tags,
  input  logic               next_pc_tag,
  input  logic [CFG_W-1:0]   chk_cfg,
  output logic               exc_pulse,
  output logic [CAUSE_W-1:0] exc_cause
);

  localparam int EXEC_BIT = CFG_W - 1;
  localparam logic [CAUSE_W-1:0] EXEC_CAUSE = CAUSE_W'(CLASSES);
  localparam int MEM_CLASS = CLASSES - 1;

  logic [CLASSES-1:0] class_hit;
  logic               exec_hit;
  logic [CAUSE_W-1:0] cause_d;

  for (genvar c = 0; c < CLASSES; c++) begin : g_cls
    assign class_hit[c] = chk_valid && (ins_class == CAUSE_W'(c)) &&
                          |(chk_cfg[c*ROLES +: ROLES] & role_tags);
  end

  assign exec_hit = chk_valid && chk_cfg[EXEC_BIT] && next_pc_tag;

  always_comb begin
    cause_d = '0;
    for (int c = 0; c < CLASSES; c++)
      if (class_hit[c]) cause_d = CAUSE_W'(c);
    if (exec_hit) cause_d = EXEC_CAUSE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_pulse <= 1'b0;
      exc_cause <= '0;
    end else begin
      exc_pulse <= exec_hit || (|class_hit);
      exc_cause <= cause_d;
    end
  end

  logic seen_r;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_r <= 1'b0;
    else        seen_r <= 1'b1;
  end

  p_idle_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_pulse |-> exc_cause == '0);

  p_valid_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_r && !$past(chk_valid)) |-> !exc_pulse);

  p_exec_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_r && $past(chk_valid && chk_cfg[EXEC_BIT] && next_pc_tag))
      |-> (exc_pulse && exc_cause == EXEC_CAUSE));

  p_zero_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_r && $past(chk_cfg == '0)) |-> !exc_pulse);

  p_no_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_r && $past(ins_class == EXEC_CAUSE && !(chk_cfg[EXEC_BIT] && next_pc_tag)))
      |-> !exc_pulse);

  p_mem_src_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_r && $past(chk_valid && ins_class == CAUSE_W'(MEM_CLASS) &&
                     chk_cfg[MEM_CLASS*ROLES] && role_tags[0] &&
                     !(chk_cfg[EXEC_BIT] && next_pc_tag)))
      |-> (exc_pulse && exc_cause == CAUSE_W'(MEM_CLASS)));

endmodule

// File: tb/tb_tag_check_unit.sv
`timescale 1ns/1ps
module tb_tag_check_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic [2:0]  ins_class = '0;
  logic [3:0]  role_tags = '0;
  logic        next_pc_tag = 1'b0;
  logic [28:0] chk_cfg = '0;
  logic        exc_pulse;
  logic [2:0]  exc_cause;

  int checks = 0;
  int failures = 0;
  bit exp_p[$];
  logic [2:0] exp_c[$];
  string exp_r[$];

  always #2.5 clk = ~clk;

  tag_check_unit dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .ins_class(ins_class),
    .role_tags(role_tags), .next_pc_tag(next_pc_tag), .chk_cfg(chk_cfg),
    .exc_pulse(exc_pulse), .exc_cause(exc_cause));

  function automatic logic [28:0] mask_of(int cls, logic [3:0] m);
    logic [28:0] r = '0;
    r[cls*4 +: 4] = m;
    return r;
  endfunction

  task automatic drive(bit v, int cls, logic [3:0] tg, bit pc, logic [28:0] cfg, string req);
    bit p;
    logic [2:0] c;
    @(negedge clk);
    chk_valid = v; ins_class = 3'(cls); role_tags = tg; next_pc_tag = pc; chk_cfg = cfg;
    p = 1'b0; c = 3'd0;
    if (v && cls < 7 && (cfg[cls*4 +: 4] & tg) != 4'd0) begin p = 1'b1; c = 3'(cls); end
    if (v && cfg[28] && pc) begin p = 1'b1; c = 3'd7; end
    exp_p.push_back(p); exp_c.push_back(c); exp_r.push_back(req);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_p.size() > 0) begin
      bit p; logic [2:0] c; string r;
      p = exp_p.pop_front(); c = exp_c.pop_front(); r = exp_r.pop_front();
      checks++;
      if (exc_pulse !== p || exc_cause !== c) begin
        failures++;
        $display("FAIL %s: got pulse=%0b cause=%0d, expected pulse=%0b cause=%0d",
                 r, exc_pulse, exc_cause, p, c);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (exc_pulse !== 1'b0 || exc_cause !== 3'd0) begin
      failures++;
      $display("FAIL R1: got pulse=%0b cause=%0d, expected 0 0", exc_pulse, exc_cause);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (exc_pulse !== 1'b0 || exc_cause !== 3'd0) begin
      failures++;
      $display("FAIL R1: got pulse=%0b cause=%0d after reset, expected 0 0", exc_pulse, exc_cause);
    end

    drive(1, 0, 4'hF, 0, 29'h0FFF_FFF0, "R3");
    drive(1, 0, 4'b0010, 0, mask_of(0, 4'b0010), "R2");
    drive(0, 0, 4'h0, 0, '0, "R9");
    for (int c = 0; c < 7; c++) drive(1, c, 4'hF, 0, mask_of(c, 4'hF), "R2");
    drive(1, 6, 4'b0001, 0, mask_of(6, 4'b0001), "R10");
    drive(1, 6, 4'b1000, 0, mask_of(6, 4'b1000), "R10");
    drive(1, 6, 4'b0100, 0, mask_of(6, 4'b1011), "R10");
    drive(1, 6, 4'b0010, 0, mask_of(6, 4'b0010), "R10");
    drive(1, 2, 4'b0001, 0, mask_of(6, 4'hF), "R3");
    drive(1, 0, 4'h0, 1, 29'h1000_0000, "R4");
    drive(1, 2, 4'hF, 1, 29'h1FFF_FFFF, "R4");
    drive(1, 3, 4'h0, 1, 29'h0FFF_FFFF, "R5");
    drive(1, 4, 4'hF, 1, '0, "R6");
    drive(1, 6, 4'hF, 1, '0, "R6");
    drive(0, 1, 4'hF, 1, 29'h1FFF_FFFF, "R7");
    drive(1, 7, 4'hF, 0, 29'h1FFF_FFFF, "R8");
    drive(1, 7, 4'h0, 1, 29'h1000_0000, "R8");
    drive(1, 5, 4'b0100, 0, mask_of(5, 4'b0100), "R2");
    drive(0, 0, 4'h0, 0, '0, "R9");
    drive(0, 0, 4'h0, 0, '0, "R9");
    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule